// File: doc/BRIEF.md
# Data-strobe character transmitter

This block turns link characters into a two-wire data-strobe bit stream. A programmable divider sets the bit rate: each bit lasts `bit_div + 1` system clocks. The data line carries the bit value. The strobe line toggles whenever the data line keeps its value, so exactly one of the two lines changes at every bit boundary.

When nothing is requested the block sends NULLs. At each character boundary it picks the next character in this order: a pending time code, then a flow-control token (FCT), then a normal character (N-Char, which is a data byte or an end-of-packet marker), then NULL. Two restriction inputs limit what may be sent while a link is still coming up. The FCT and N-Char requests follow a hold-until-acknowledge handshake with combinational acknowledges. A time code is requested with a one-cycle pulse and is held inside the block until it can go out.

Each character starts with an odd-parity bit and a flag bit, followed by its payload sent least-significant bit first. The parity bit covers the previous character's payload together with the current parity and flag bits.

Top module: `ds_char_tx`

## Requirements
- R1: While `tx_en` is low (and in reset) both `ds_d` and `ds_s` are 0, no acknowledge is given, any pending time code is dropped and a `tc_stb` pulse is ignored. The parity history restarts at 0.
- R2: The first bit is driven on the first enabled clock edge. Each bit then holds for exactly `bit_div + 1` clocks, and `bit_div` is sampled when a bit starts.
- R3: At every bit boundary exactly one of `ds_d` and `ds_s` changes. `ds_s` toggles when the new bit equals the previous `ds_d`.
- R4: Character formats, each sent first bit first:
  - FCT is parity, 1, 0, 0.
  - The escape character is parity, 1, 1, 1.
  - NULL is escape followed by FCT.
  - A data character is parity, 0, then `nchar_byte` bit 0 through bit 7.
  - With `nchar_flag`=1, `nchar_byte[0]`=0 gives end-of-packet (parity, 1, 1, 0) and `nchar_byte[0]`=1 gives error-end (parity, 1, 0, 1).
  - A time code is escape followed by a data character carrying `tc_count` in bits 5:0 and `tc_ctrl` in bits 7:6.
- R5: The parity bit is chosen so that the XOR of the previous character's payload bits, the parity bit and the flag bit is 1.
- R6: At a character boundary the next character is a pending time code first, then FCT, then N-Char, then NULL.
- R7: While `only_null` is high only NULLs are sent, both acknowledges stay low, and requests, including a pending time code, are kept for later.
- R8: While `only_null_fct` is high (and `only_null` is low) FCTs and NULLs may be sent, `nchar_ack` stays low and a pending time code waits.
- R9: `fct_ack` is high combinationally in the clock where an FCT character is loaded, and only while `fct_req` is high. A held `fct_req` produces exactly one FCT per acknowledge.
- R10: `nchar_ack` is high only in the clock where the N-Char is loaded and never while `fct_req` is high.
- R11: A `tc_stb` pulse latches `{tc_ctrl, tc_count}`. A later pulse before transmission overwrites the latched value, and each latched time code is sent once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmitter enable; low resets the transmitter |
| only_null | input | 1 | Restrict output to NULL characters |
| only_null_fct | input | 1 | Restrict output to NULL and FCT characters |
| bit_div | input | DIV_W | Bit period minus one, in clocks |
| fct_req | input | 1 | FCT request, held until acknowledged |
| fct_ack | output | 1 | FCT acknowledge (combinational) |
| nchar_req | input | 1 | N-Char request, held until acknowledged |
| nchar_flag | input | 1 | 1 = end marker, 0 = data byte |
| nchar_byte | input | 8 | Data byte, or bit 0 selects the end-marker kind |
| nchar_ack | output | 1 | N-Char acknowledge (combinational) |
| tc_stb | input | 1 | One-cycle time code request |
| tc_ctrl | input | 2 | Time code control bits |
| tc_count | input | 6 | Time code counter value |
| ds_d | output | 1 | Serial data line |
| ds_s | output | 1 | Serial strobe line |

## Verification
The assertions check the following on every cycle:
- exactly one line moves per bit and the lines stay still between bits;
- the lines are low while disabled and no bit starts in the clock after a bit start when the divider is non-zero;
- both restriction modes suppress the acknowledges they forbid and FCT masks the N-Char acknowledge;
- a strobe always leaves a time code pending.

Only the bench's cycle-by-cycle reference model can show that the bit sequence, the parity chain across characters and the priority order come out right. It compares the output lines and acknowledges on every clock across idle NULLs, each character kind, contention, both restriction modes, several divider values and a disable in mid-character.

// File: rtl/ds_tx_pkg.sv
package ds_tx_pkg;

  localparam int BYTE_W = 8;
  localparam int CTRL_W = 4;
  localparam int DATA_W = BYTE_W + 2;
  localparam int SEQ_W  = CTRL_W + DATA_W;
  localparam int LEN_W  = $clog2(SEQ_W + 1);

  localparam logic [1:0] CODE_FCT = 2'd0;
  localparam logic [1:0] CODE_EOP = 2'd1;
  localparam logic [1:0] CODE_EEP = 2'd2;
  localparam logic [1:0] CODE_ESC = 2'd3;

  typedef enum logic [1:0] {
    K_NULL  = 2'd0,
    K_FCT   = 2'd1,
    K_NCHAR = 2'd2,
    K_TIME  = 2'd3
  } char_kind_e;

  typedef struct packed {
    logic [SEQ_W-1:0] bits;   // bit 0 leaves first
    logic [LEN_W-1:0] len;    // number of valid bits
    logic             acc;    // XOR of the last character's payload
  } char_seq_t;

  // Control character: parity, flag=1, code LSB first.
  // Parity = ~(prev ^ flag) = prev when flag is 1.
  function automatic logic [CTRL_W-1:0] ctrl_char(input logic prev,
                                                  input logic [1:0] code);
    return {code[1], code[0], 1'b1, prev};
  endfunction

  // Data character: parity, flag=0, byte LSB first.
  function automatic logic [DATA_W-1:0] data_char(input logic prev,
                                                  input logic [BYTE_W-1:0] b);
    return {b, 1'b0, ~prev};
  endfunction

  function automatic char_seq_t build_char(input char_kind_e kind,
                                           input logic flag,
                                           input logic [BYTE_W-1:0] b,
                                           input logic [BYTE_W-1:0] tword,
                                           input logic prev);
    char_seq_t r;
    r = '0;
    unique case (kind)
      K_FCT: begin
        r.bits = SEQ_W'(ctrl_char(prev, CODE_FCT));
        r.len  = LEN_W'(CTRL_W);
        r.acc  = 1'b0;
      end
      K_NCHAR: begin
        if (flag) begin
          r.bits = SEQ_W'(ctrl_char(prev, b[0] ? CODE_EEP : CODE_EOP));
          r.len  = LEN_W'(CTRL_W);
          r.acc  = 1'b1;
        end else begin
          r.bits = SEQ_W'(data_char(prev, b));
          r.len  = LEN_W'(DATA_W);
          r.acc  = ^b;
        end
      end
      K_TIME: begin
        // escape payload XOR is 0, so the data part sees prev = 0
        r.bits = {data_char(1'b0, tword), ctrl_char(prev, CODE_ESC)};
        r.len  = LEN_W'(SEQ_W);
        r.acc  = ^tword;
      end
      default: begin
        r.bits = SEQ_W'({ctrl_char(1'b0, CODE_FCT), ctrl_char(prev, CODE_ESC)});
        r.len  = LEN_W'(2 * CTRL_W);
        r.acc  = 1'b0;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ds_bit_timer.sv
module ds_bit_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && !rst && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !en)       cnt <= '0;
    else if (cnt == '0)   cnt <= div;
    else                  cnt <= cnt - 1'b1;
  end

  // R2: with a non-zero divider a bit start is never followed at once by another
  assert_bit_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0) |=> !tick);

endmodule

// File: rtl/ds_char_picker.sv
module ds_char_picker
  import ds_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              boundary,
  input  logic              only_null,
  input  logic              only_null_fct,
  input  logic              fct_req,
  input  logic              nchar_req,
  input  logic              tc_stb,
  input  logic [1:0]        tc_ctrl,
  input  logic [5:0]        tc_count,
  output char_kind_e        kind,
  output logic [BYTE_W-1:0] tc_word,
  output logic              fct_ack,
  output logic              nchar_ack
);
  logic tc_pend;
  logic allow_all, allow_fct, tc_sent;

  assign allow_fct = !only_null;
  assign allow_all = !only_null && !only_null_fct;

  always_comb begin
    if (tc_pend && allow_all)        kind = K_TIME;
    else if (fct_req && allow_fct)   kind = K_FCT;
    else if (nchar_req && allow_all) kind = K_NCHAR;
    else                             kind = K_NULL;
  end

  assign fct_ack   = boundary && (kind == K_FCT);
  assign nchar_ack = boundary && (kind == K_NCHAR);
  assign tc_sent   = boundary && (kind == K_TIME);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      tc_pend <= 1'b0;
      tc_word <= '0;
    end else if (tc_stb) begin
      tc_pend <= 1'b1;
      tc_word <= {tc_ctrl, tc_count};
    end else if (tc_sent) begin
      tc_pend <= 1'b0;
    end
  end

  // R11: a strobe while enabled leaves a time code pending
  assert_tc_latched_R11: assert property (@(posedge clk) disable iff (rst)
    (en && tc_stb) |=> tc_pend);
  // R7: only-NULL mode acknowledges nothing
  assert_null_mode_silent_R7: assert property (@(posedge clk) disable iff (rst)
    only_null |-> (!fct_ack && !nchar_ack));
  // R8: NULL/FCT mode never acknowledges an N-Char
  assert_fct_mode_no_nchar_R8: assert property (@(posedge clk) disable iff (rst)
    only_null_fct |-> !nchar_ack);
  // R10: an FCT request masks the N-Char acknowledge
  assert_fct_masks_nchar_R10: assert property (@(posedge clk) disable iff (rst)
    nchar_ack |-> !fct_req);

endmodule

// File: rtl/ds_shift_out.sv
module ds_shift_out
  import ds_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      tick,
  input  char_seq_t seq,
  output logic      empty,
  output logic      acc,
  output logic      ds_d,
  output logic      ds_s
);
  logic [SEQ_W-1:0] sh;
  logic [LEN_W-1:0] left;
  logic             next_bit;

  assign empty    = (left == '0);
  assign next_bit = empty ? seq.bits[0] : sh[0];

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sh   <= '0;
      left <= '0;
      acc  <= 1'b0;
      ds_d <= 1'b0;
      ds_s <= 1'b0;
    end else if (tick) begin
      if (empty) begin
        sh   <= seq.bits >> 1;
        left <= seq.len - 1'b1;
        acc  <= seq.acc;
      end else begin
        sh   <= sh >> 1;
        left <= left - 1'b1;
      end
      ds_d <= next_bit;
      ds_s <= (next_bit == ds_d) ? ~ds_s : ds_s;
    end
  end

  // R3: exactly one line moves at each bit start
  assert_one_line_moves_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> ($countones({ds_d ^ $past(ds_d), ds_s ^ $past(ds_s)}) == 1));
  // R2: lines hold between bit starts
  assert_hold_between_bits_R2: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> ($stable(ds_d) && $stable(ds_s)));

endmodule

// File: rtl/ds_char_tx.sv
module ds_char_tx
  import ds_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             only_null,
  input  logic             only_null_fct,
  input  logic [DIV_W-1:0] bit_div,
  input  logic             fct_req,
  output logic             fct_ack,
  input  logic             nchar_req,
  input  logic             nchar_flag,
  input  logic [7:0]       nchar_byte,
  output logic             nchar_ack,
  input  logic             tc_stb,
  input  logic [1:0]       tc_ctrl,
  input  logic [5:0]       tc_count,
  output logic             ds_d,
  output logic             ds_s
);
  logic              tick, empty, boundary, acc;
  char_kind_e        kind;
  logic [BYTE_W-1:0] tc_word;
  char_seq_t         seq;

  assign boundary = tick && empty;
  assign seq      = build_char(kind, nchar_flag, nchar_byte, tc_word, acc);

  ds_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst(rst), .en(tx_en), .div(bit_div), .tick(tick));

  ds_char_picker u_picker (
    .clk(clk), .rst(rst), .en(tx_en), .boundary(boundary),
    .only_null(only_null), .only_null_fct(only_null_fct),
    .fct_req(fct_req), .nchar_req(nchar_req),
    .tc_stb(tc_stb), .tc_ctrl(tc_ctrl), .tc_count(tc_count),
    .kind(kind), .tc_word(tc_word),
    .fct_ack(fct_ack), .nchar_ack(nchar_ack));

  ds_shift_out u_shift (
    .clk(clk), .rst(rst), .en(tx_en), .tick(tick), .seq(seq),
    .empty(empty), .acc(acc), .ds_d(ds_d), .ds_s(ds_s));

  // R1: lines are low after a disabled clock
  assert_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (!ds_d && !ds_s));

endmodule

// File: tb/ds_char_tx_tb.sv
module ds_char_tx_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1, tx_en = 1'b0, only_null = 1'b0, only_null_fct = 1'b0;
  logic [7:0] bit_div = 8'd0;
  logic       fct_req = 1'b0, nchar_req = 1'b0, nchar_flag = 1'b0, tc_stb = 1'b0;
  logic [7:0] nchar_byte = 8'd0;
  logic [1:0] tc_ctrl = 2'd0;
  logic [5:0] tc_count = 6'd0;
  logic       fct_ack, nchar_ack, ds_d, ds_s;

  always #10 clk = ~clk;

  ds_char_tx u_dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .only_null(only_null),
    .only_null_fct(only_null_fct), .bit_div(bit_div),
    .fct_req(fct_req), .fct_ack(fct_ack),
    .nchar_req(nchar_req), .nchar_flag(nchar_flag), .nchar_byte(nchar_byte),
    .nchar_ack(nchar_ack), .tc_stb(tc_stb), .tc_ctrl(tc_ctrl),
    .tc_count(tc_count), .ds_d(ds_d), .ds_s(ds_s));

  int    vectors = 0, miscompares = 0;
  string tag = "R1";

  // reference model state
  int   m_tmr = 0;
  bit   m_q[$];
  bit   m_acc = 0, m_d = 0, m_s = 0, m_tpend = 0;
  bit [7:0] m_tword = 0;

  task automatic check(string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // 0 NULL, 1 FCT, 2 N-Char, 3 time code
  function automatic int choose();
    if (!only_null && !only_null_fct && m_tpend) return 3;
    if (!only_null && fct_req) return 1;
    if (!only_null && !only_null_fct && nchar_req) return 2;
    return 0;
  endfunction

  task automatic push_ctrl(bit [1:0] c);
    bit p = ~(m_acc ^ 1'b1);
    m_q.push_back(p); m_q.push_back(1'b1);
    m_q.push_back(c[0]); m_q.push_back(c[1]);
    m_acc = c[0] ^ c[1];
  endtask

  task automatic push_data(bit [7:0] v);
    bit p = ~m_acc;
    m_q.push_back(p); m_q.push_back(1'b0);
    m_acc = 1'b0;
    for (int i = 0; i < 8; i++) begin
      m_q.push_back(v[i]);
      m_acc = m_acc ^ v[i];
    end
  endtask

  task automatic cycle();
    bit bnd, fa, na, b;
    int k;
    #1;
    bnd = tx_en && !rst && m_tmr == 0 && m_q.size() == 0;
    k = choose();
    check("fct_ack (R9 R6)", fct_ack, bnd && k == 1);
    check("nchar_ack (R10 R6)", nchar_ack, bnd && k == 2);
    fa = fct_ack; na = nchar_ack;
    @(posedge clk);
    if (rst || !tx_en) begin
      m_tmr = 0; m_q.delete(); m_acc = 0; m_d = 0; m_s = 0; m_tpend = 0; m_tword = 0;
    end else begin
      if (m_tmr != 0) m_tmr--;
      else begin
        if (m_q.size() == 0) begin
          case (k)
            1: push_ctrl(2'd0);
            2: if (nchar_flag) push_ctrl(nchar_byte[0] ? 2'd2 : 2'd1);
               else push_data(nchar_byte);
            3: begin push_ctrl(2'd3); push_data(m_tword); end
            default: begin push_ctrl(2'd3); push_ctrl(2'd0); end
          endcase
        end
        b = m_q.pop_front();
        if (b == m_d) m_s = ~m_s;
        m_d = b;
        m_tmr = bit_div;
      end
      if (tc_stb) begin m_tpend = 1; m_tword = {tc_ctrl, tc_count}; end
      else if (bnd && k == 3) m_tpend = 0;
    end
    @(negedge clk);
    check("ds_d (R3 R4 R5)", ds_d, m_d);
    check("ds_s (R3)", ds_s, m_s);
    if (fa) fct_req = 1'b0;
    if (na) nchar_req = 1'b0;
    tc_stb = 1'b0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic send_tc(bit [1:0] c, bit [5:0] t);
    tc_ctrl = c; tc_count = t; tc_stb = 1'b1;
  endtask

  initial begin
    #(20 * 150000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    tag = "R1 reset"; run(3);
    check("R1 reset ds_d", ds_d, 1'b0);
    check("R1 reset ds_s", ds_s, 1'b0);
    rst = 1'b0; run(2);

    tag = "R2 R4 R5 idle NULLs"; tx_en = 1'b1; run(40);
    tag = "R9 FCT"; fct_req = 1'b1; run(20);
    tag = "R4 R5 data"; nchar_req = 1'b1; nchar_byte = 8'hA5; run(24);
    nchar_req = 1'b1; nchar_byte = 8'h3C; run(24);
    tag = "R4 EOP"; nchar_req = 1'b1; nchar_flag = 1'b1; nchar_byte = 8'h00; run(16);
    tag = "R4 EEP"; nchar_req = 1'b1; nchar_byte = 8'h01; run(16);
    nchar_flag = 1'b0;
    tag = "R11 time code"; send_tc(2'd2, 6'd37); run(40);
    tag = "R11 overwrite"; send_tc(2'd1, 6'd5); cycle(); send_tc(2'd3, 6'd62); run(40);
    tag = "R6 R10 contention"; fct_req = 1'b1; nchar_req = 1'b1; nchar_byte = 8'h7E;
    send_tc(2'd0, 6'd9); run(80);

    tag = "R7 only NULL"; only_null = 1'b1; fct_req = 1'b1; nchar_req = 1'b1;
    nchar_byte = 8'h81; send_tc(2'd1, 6'd17); run(48);
    check("R7 fct still held", fct_req, 1'b1);
    only_null = 1'b0; run(60);

    tag = "R8 only NULL FCT"; only_null_fct = 1'b1; nchar_req = 1'b1; nchar_byte = 8'h55;
    fct_req = 1'b1; send_tc(2'd2, 6'd44); run(48);
    check("R8 nchar still held", nchar_req, 1'b1);
    only_null_fct = 1'b0; run(60);

    tag = "R2 divider 3"; bit_div = 8'd3; nchar_req = 1'b1; nchar_byte = 8'hC3; run(120);
    tag = "R2 divider 7"; bit_div = 8'd7; fct_req = 1'b1; run(160);

    tag = "R1 disable mid-character"; bit_div = 8'd1; send_tc(2'd3, 6'd1); run(9);
    tx_en = 1'b0; send_tc(2'd2, 6'd2); run(3);
    check("R1 disabled ds_d", ds_d, 1'b0);
    check("R1 disabled ds_s", ds_s, 1'b0);
    tx_en = 1'b1; bit_div = 8'd0; run(40);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule